// File: doc/BRIEF.md
# Watchdog Reset Timer

This block is a watchdog that counts whole seconds and pulls an active-low reset line when software fails to service it in time. A prescaler divides the system clock into a one-second tick; the number of clock cycles per second is a parameter, so a bench can shorten the second to a handful of cycles. The remaining-time counter is six bits wide, which gives timeouts from 1 to 63 seconds at one-second resolution.

Software reaches the block through a plain register write port, the kind a serial-bus slave back-end would present: one register holds the timeout, one holds the enable bit and a two-bit repeat-rate field, and any write to a third address is a service strobe that reloads the counter. Once the count runs out, the block raises an expired flag and issues a train of reset pulses: each is low for a parameterised number of seconds and the train repeats at a programmable period until software services the block or disables it.

Top module: `wdt_reset_timer`

## Requirements
- R1: After reset, wdrst_n is 1, expired is 0, the block is disabled, and the timeout and rate fields are 0.
- R2: Register map on wr_addr: 0 stores the timeout from wr_data[5:0]; 1 stores the enable from wr_data[0] and the rate from wr_data[2:1]; 2 is the service strobe (data ignored); a write to address 3 has no effect.
- R3: One second is TICK_DIV clock cycles, and the prescaler restarts from zero at every reload, so a count always starts on a full second.
- R4: With timeout T loaded by a reload at clock edge E, expired rises and wdrst_n falls together at edge E + T*TICK_DIV.
- R5: A reload with a stored timeout of 0 leaves the block idle: it never expires.
- R6: A service write while enabled reloads the counter from the stored timeout and clears expired, with wdrst_n back at 1 after that edge; a service write while disabled has no effect.
- R7: Writing the enable bit from 0 to 1 performs a reload; writing it to 0 stops the count and clears expired and the reset output at that edge.
- R8: While expired, wdrst_n is low for PULSE_SEC seconds at the start of every period of 2^(rate+1) seconds (rate 0 = 2 s, 1 = 4 s, 2 = 8 s, 3 = 16 s), the first period starting at the expiry edge.
- R9: Writing the timeout while a count runs does not change that count; the new value is used from the next reload.
- R10: A service write in the same cycle as the tick that would expire the count wins: no expiry, no reset pulse, and a fresh count starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 2 | Register select for the write |
| wr_data | input | 8 | Write data |
| wdrst_n | output | 1 | Active-low watchdog reset output |
| expired | output | 1 | High while the watchdog has timed out and not been serviced |

## Verification
The service strobe and the final one-second tick of a count can land on the same clock edge, one asking for a reload and the other for expiry. The bench provokes this by enabling a one-second timeout and placing the service write exactly TICK_DIV cycles later, on the edge the expiry would occur. It judges the outcome at the ports: expired must stay low and wdrst_n high after that edge, and the next expiry must come a full timeout after the service write rather than at once.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int unsigned RATE_W = 2;
    localparam int unsigned PH_W   = 5;

    typedef enum logic [1:0] {
        REG_TMO   = 2'd0,
        REG_CTRL  = 2'd1,
        REG_KICK  = 2'd2,
        REG_SPARE = 2'd3
    } wdt_addr_e;

    // repeat period in seconds: 2, 4, 8 or 16
    function automatic logic [PH_W-1:0] period_sec(input logic [RATE_W-1:0] rate);
        return PH_W'(2) << rate;
    endfunction

endpackage

// File: rtl/wdt_tick_gen.sv
module wdt_tick_gen #(
    parameter int unsigned TICK_DIV = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clear,
    output logic tick
);
    localparam int unsigned CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear || !run) begin
            cnt_d = '0;
        end else if (cnt_q == LAST) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign tick = run && (cnt_q == LAST);

endmodule

// File: rtl/wdt_pulse_gen.sv
module wdt_pulse_gen
    import wdt_pkg::*;
#(
    parameter int unsigned PULSE_SEC = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              start,
    input  logic              active_d,
    input  logic [RATE_W-1:0] rate,
    output logic              low
);
    typedef struct packed {
        logic [PH_W-1:0] phase;
        logic            low;
    } pg_t;

    pg_t pg_d, pg_q;
    logic [PH_W-1:0] per;

    always_comb begin
        per  = period_sec(rate);
        pg_d = pg_q;
        if (start || !active_d) begin
            pg_d.phase = '0;
        end else if (tick) begin
            if (pg_q.phase >= per - PH_W'(1)) begin
                pg_d.phase = '0;
            end else begin
                pg_d.phase = pg_q.phase + PH_W'(1);
            end
        end
        pg_d.low = active_d && (pg_d.phase < PH_W'(PULSE_SEC));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pg_q <= '0;
        end else begin
            pg_q <= pg_d;
        end
    end

    assign low = pg_q.low;

endmodule

// File: rtl/wdt_reset_timer.sv
module wdt_reset_timer
    import wdt_pkg::*;
#(
    parameter int unsigned TICK_DIV  = 1000,
    parameter int unsigned TMO_W     = 6,
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned PULSE_SEC = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wdrst_n,
    output logic              expired
);
    typedef struct packed {
        logic [TMO_W-1:0]  tmo;
        logic              en;
        logic [RATE_W-1:0] rate;
        logic [TMO_W-1:0]  remain;
        logic              run;
        logic              expired;
    } st_t;

    st_t  st_d, st_q;
    logic wr_tmo, wr_ctrl, wr_kick;
    logic reload, start, tick, low, en_q;

    assign wr_tmo  = wr_en && (wdt_addr_e'(wr_addr) == REG_TMO);
    assign wr_ctrl = wr_en && (wdt_addr_e'(wr_addr) == REG_CTRL);
    assign wr_kick = wr_en && (wdt_addr_e'(wr_addr) == REG_KICK);

    always_comb begin
        st_d   = st_q;
        start  = 1'b0;
        if (wr_tmo) begin
            st_d.tmo = wr_data[TMO_W-1:0];
        end
        if (wr_ctrl) begin
            st_d.en   = wr_data[0];
            st_d.rate = wr_data[RATE_W:1];
        end
        reload = st_d.en && (wr_kick || (wr_ctrl && !st_q.en));
        if (!st_d.en) begin
            st_d.run     = 1'b0;
            st_d.expired = 1'b0;
            st_d.remain  = '0;
        end else if (reload) begin
            // the stored value, not one written this cycle, seeds the count
            st_d.expired = 1'b0;
            st_d.run     = (st_q.tmo != '0);
            st_d.remain  = st_q.tmo;
        end else if (st_q.run && !st_q.expired && tick) begin
            if (st_q.remain == TMO_W'(1)) begin
                st_d.expired = 1'b1;
                st_d.remain  = '0;
                start        = 1'b1;
            end else begin
                st_d.remain = st_q.remain - TMO_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    wdt_tick_gen #(
        .TICK_DIV (TICK_DIV)
    ) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (st_q.run),
        .clear (reload || !st_d.en),
        .tick  (tick)
    );

    wdt_pulse_gen #(
        .PULSE_SEC (PULSE_SEC)
    ) u_pulse (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .start    (start),
        .active_d (st_d.expired),
        .rate     (st_d.rate),
        .low      (low)
    );

    assign en_q    = st_q.en;
    assign wdrst_n = !low;
    assign expired = st_q.expired;

endmodule

// File: rtl/wdt_reset_timer_chk.sv
module wdt_reset_timer_chk #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [1:0]        wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              wdrst_n,
    input logic              expired,
    input logic              tick,
    input logic              en_q
);

    // R8: reset is only driven while the timer is in the expired state
    a_r8_low_needs_expiry: assert property (@(posedge clk) disable iff (!rst_n)
        !wdrst_n |-> expired);

    // R4: the reset line falls on the very edge that expiry is flagged
    a_r4_low_at_expiry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(expired) |-> !wdrst_n);

    // R3: expiry only ever happens on a one-second tick
    a_r3_expiry_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(expired) |-> $past(tick));

    // R6: a service write while enabled clears expiry and the reset output
    a_r6_kick_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd2 && en_q) |=> (!expired && wdrst_n));

    // R7: clearing the enable bit stops everything at once
    a_r7_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd1 && !wr_data[0]) |=> (!expired && wdrst_n));

    // R5: with the block disabled nothing can expire
    a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> !expired);

endmodule

bind wdt_reset_timer wdt_reset_timer_chk #(
    .DATA_W (DATA_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .wdrst_n (wdrst_n),
    .expired (expired),
    .tick    (tick),
    .en_q    (en_q)
);

// File: tb/tb_wdt_reset_timer.sv
`timescale 1ns/1ps
module tb_wdt_reset_timer;
    localparam int D  = 8;
    localparam int NV = 5;

    // stimulus: timeout seconds, rate code; expected: repeat period seconds
    localparam int TV_TMO [NV] = '{1, 3, 2, 5, 63};
    localparam int TV_RATE[NV] = '{0, 1, 2, 3, 0};
    localparam int TV_PER [NV] = '{2, 4, 8, 16, 2};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       wdrst_n, expired;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    wdt_reset_timer #(
        .TICK_DIV  (D),
        .TMO_W     (6),
        .DATA_W    (8),
        .PULSE_SEC (1)
    ) dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .wdrst_n (wdrst_n),
        .expired (expired)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // called at a negedge; the write lands on the next posedge
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    endtask

    task automatic wait_expired(output int n);
        n = 0;
        while (!expired && n < 2000) begin @(negedge clk); n++; end
    endtask

    task automatic count_low(output int n);
        n = 0;
        while (!wdrst_n && n < 2000) begin @(negedge clk); n++; end
    endtask

    task automatic count_high(output int n);
        n = 0;
        while (wdrst_n && n < 2000) begin @(negedge clk); n++; end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 wdrst_n after reset", int'(wdrst_n), 1);
        chk("R1 expired after reset", int'(expired), 0);
        repeat (3 * D) @(negedge clk);
        chk("R1 stays idle while disabled", int'(expired), 0);

        // table: R7 enable reload, R4 expiry time, R8 pulse width and period
        for (int i = 0; i < NV; i++) begin
            wr(2'd1, 8'h00);
            wr(2'd0, 8'(TV_TMO[i]));
            wr(2'd1, 8'({TV_RATE[i][1:0], 1'b1}));
            wait_expired(n);
            chk($sformatf("R4 R7 expiry cycles vec%0d", i), n, TV_TMO[i] * D);
            count_low(n);
            chk($sformatf("R8 pulse low cycles vec%0d", i), n, D);
            count_high(n);
            chk($sformatf("R8 pulse gap cycles vec%0d", i), n, (TV_PER[i] - 1) * D);
        end

        // R5 timeout of zero never expires
        wr(2'd1, 8'h00);
        wr(2'd0, 8'd0);
        wr(2'd1, 8'h01);
        wr(2'd2, 8'h00);
        repeat (70 * D) @(negedge clk);
        chk("R5 zero timeout no expiry", int'(expired), 0);
        chk("R5 zero timeout reset high", int'(wdrst_n), 1);

        // R6 service write ignored while disabled
        wr(2'd1, 8'h00);
        wr(2'd0, 8'd1);
        wr(2'd2, 8'h00);
        repeat (3 * D) @(negedge clk);
        chk("R6 kick while disabled ignored", int'(expired), 0);

        // R2 spare address write has no effect on a running count
        wr(2'd0, 8'd2);
        wr(2'd1, 8'h01);
        wr(2'd3, 8'hFF);
        wait_expired(n);
        chk("R2 spare write ignored", n, 2 * D - 1);

        // R6 service write while expired
        wr(2'd2, 8'h00);
        chk("R6 kick clears expired", int'(expired), 0);
        chk("R6 kick releases reset", int'(wdrst_n), 1);
        wait_expired(n);
        chk("R6 kick reloads timeout", n, 2 * D);

        // R3 prescaler restarts at a reload
        wr(2'd1, 8'h00);
        wr(2'd0, 8'd2);
        wr(2'd1, 8'h01);
        repeat (13) @(negedge clk);
        wr(2'd2, 8'h00);
        wait_expired(n);
        chk("R3 full seconds after mid-second kick", n, 2 * D);

        // R9 timeout write during a count waits for the next reload
        wr(2'd1, 8'h00);
        wr(2'd0, 8'd4);
        wr(2'd1, 8'h01);
        repeat (9) @(negedge clk);
        wr(2'd0, 8'd2);
        wait_expired(n);
        chk("R9 running count unchanged", n, 4 * D - 10);
        wr(2'd2, 8'h00);
        wait_expired(n);
        chk("R9 new timeout after reload", n, 2 * D);

        // R7 disable while expired
        wr(2'd1, 8'h00);
        chk("R7 disable clears expired", int'(expired), 0);
        chk("R7 disable releases reset", int'(wdrst_n), 1);

        // R10 service write on the expiry edge wins
        wr(2'd0, 8'd1);
        wr(2'd1, 8'h01);
        repeat (D - 1) @(negedge clk);
        wr(2'd2, 8'h00);
        chk("R10 kick beats expiry flag", int'(expired), 0);
        chk("R10 kick beats expiry reset", int'(wdrst_n), 1);
        wait_expired(n);
        chk("R10 fresh count after kick", n, D);

        wr(2'd1, 8'h00);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule